// File: doc/BRIEF.md
# CAN Controller Operating-Mode Register

This block holds the operating-mode control word of a CAN / CAN FD protocol controller. The host reads and writes one 32-bit word on its own clock. The block applies the write rules for the guarded mode bits and runs the clock-stop handshake. It moves the initialization bit and the static mode bits into the protocol clock domain. The protocol engine feeds back two status levels, transmit-request-pending and bus-idle, and the block brings both into the host domain through synchronizers.

The initialization bit crosses into the protocol domain through a toggle request and acknowledge handshake. The value the host reads back for it changes only after the protocol side has taken the new value. For this reason the host should poll the read value before it writes the bit again. The block also exports two enables on the host clock. One gates writes to the protected configuration registers. The other gates writes to the test register.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the read word is 0x00000001: only bit 0 (initialization) is set. The protocol-side init output is 1, and every other mode output and both host enables are 0.
- R2: The word's fields are as follows. Bit 0 is init. Bit 1 is config-change enable. Bit 2 is restricted mode. Bit 3 is clock-stop acknowledge, which is read-only. Bit 4 is clock-stop request. Bit 5 is bus monitoring. Bit 6 is no-retransmit. Bit 7 is test enable. Bit 8 is FD enable. Bit 9 is bit-rate switch. Bit 12 is protocol-exception disable. Bit 13 is edge filter. Bit 14 is transmit pause. Writes to bit 3, bits 11:10 and bits 31:15 have no effect, and those reserved bits always read 0.
- R3: Bit 5 and bit 2 can change from 0 to 1 only when bit 1 and the read-back bit 0 are both 1 before the write. Writing 0 to either bit clears it in all states.
- R4: The config-change enable output is 1 only while bit 1 and the read-back bit 0 are both 1. The test-write enable output equals bit 7.
- R5: A written init value reaches the protocol-side init output through a synchronizer. The read-back bit 0 changes at least 4 host cycles after the write. It changes only after the protocol-side output already holds the new value.
- R6: While bit 4 is 1, the requested init value is held at 1. A write of 0 to bit 0 in that state has no effect.
- R7: Bit 3 becomes 1 only when all of these hold: bit 4 is 1, the read-back bit 0 is 1, the synchronized transmit-pending input is 0, and the synchronized bus-idle input is 1. Bit 3 returns to 0 one host cycle after bit 4 is cleared, and bit 0 stays 1.
- R8: The protocol-side bit-rate-switch output is bit 9 AND bit 8. It is 0 whenever FD is disabled.
- R9: Bits 2, 5, 6, 7, 8, 12, 13 and 14 reach the protocol side through synchronizers on their own outputs, without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_h | input | 1 | Host clock |
| rst_hn | input | 1 | Host-domain asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the mode word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current mode word |
| cfg_chg_en | output | 1 | Write enable for protected configuration registers |
| test_wr_en | output | 1 | Write enable for the test register |
| clk_p | input | 1 | Protocol clock |
| rst_pn | input | 1 | Protocol-domain asynchronous active-low reset |
| tx_pend_p | input | 1 | Transmit requests still pending (protocol domain) |
| bus_idle_p | input | 1 | CAN bus idle (protocol domain) |
| p_init | output | 1 | Initialization state for the protocol engine |
| p_fd_en | output | 1 | FD operation enable |
| p_brs_en | output | 1 | Effective bit-rate-switch enable |
| p_mon | output | 1 | Bus monitoring mode |
| p_restrict | output | 1 | Restricted operation mode |
| p_no_retx | output | 1 | Automatic retransmission disabled |
| p_tx_pause | output | 1 | Idle gap of two bit times after own transmission |
| p_edge_filt | output | 1 | Edge filtering during bus integration |
| p_pexc_dis | output | 1 | Protocol exception handling disabled |
| p_test | output | 1 | Test mode |

## Verification
The bench builds the block with the default synchronizer depth of two stages. It runs the protocol clock at a period unrelated to the host clock, so the init handshake, the mode-bit synchronizers and the status synchronizers are exercised with varying phase. This setting shows the full read-back delay of init. The bench measures that delay and checks its lower bound. It also confirms that the protocol-side init has already settled when the read-back changes. The same setting makes CSA wait until both status inputs have passed their synchronizers.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int REG_W = 32;

  // Bit positions of the host-visible mode word
  localparam int B_INIT  = 0;
  localparam int B_CCE   = 1;
  localparam int B_ROM   = 2;
  localparam int B_CSA   = 3;
  localparam int B_CSR   = 4;
  localparam int B_MON   = 5;
  localparam int B_NORTX = 6;
  localparam int B_TST   = 7;
  localparam int B_FD    = 8;
  localparam int B_BRS   = 9;
  localparam int B_PEXD  = 12;
  localparam int B_EFLT  = 13;
  localparam int B_PAUSE = 14;

  // Number of static mode bits forwarded to the protocol domain
  localparam int N_MODE = 9;

  typedef struct packed {
    logic pause;
    logic eflt;
    logic pexd;
    logic brs;
    logic fd;
    logic tst;
    logic nortx;
    logic mon;
    logic rom;
    logic csr;
    logic cce;
  } ctl_t;
endpackage

// File: rtl/cmc_sync.sv
module cmc_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] src;
      if (s == 0) begin : g_first
        assign src = d;
      end else begin : g_next
        assign src = stg[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= src;
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmc_init_xfer.sv
module cmc_init_xfer #(
  parameter int STAGES = 2
) (
  input  logic clk_h,
  input  logic rst_hn,
  input  logic init_want,
  output logic init_seen,
  input  logic clk_p,
  input  logic rst_pn,
  output logic init_p
);
  // host side state
  logic req_tgl, req_tgl_n;
  logic hold_q, hold_n;
  logic busy_q, busy_n;
  logic seen_q, seen_n;
  logic ack_s;
  // protocol side state
  logic req_s;
  logic ack_tgl, ack_tgl_n;
  logic initp_q, initp_n;

  // ---------------- host domain ----------------
  cmc_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk(clk_h), .rst_n(rst_hn), .d(ack_tgl), .q(ack_s)
  );

  always_comb begin
    req_tgl_n = req_tgl;
    hold_n    = hold_q;
    busy_n    = busy_q;
    seen_n    = seen_q;
    if (busy_q) begin
      if (ack_s == req_tgl) begin
        seen_n = hold_q;
        busy_n = 1'b0;
      end
    end else if (init_want != seen_q) begin
      req_tgl_n = ~req_tgl;
      hold_n    = init_want;
      busy_n    = 1'b1;
    end
  end

  always_ff @(posedge clk_h or negedge rst_hn) begin
    if (!rst_hn) begin
      req_tgl <= 1'b0;
      hold_q  <= 1'b1;
      busy_q  <= 1'b0;
      seen_q  <= 1'b1;
    end else begin
      req_tgl <= req_tgl_n;
      hold_q  <= hold_n;
      busy_q  <= busy_n;
      seen_q  <= seen_n;
    end
  end

  assign init_seen = seen_q;

  // ---------------- protocol domain ----------------
  cmc_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk(clk_p), .rst_n(rst_pn), .d(req_tgl), .q(req_s)
  );

  // hold_q is stable while a request is outstanding
  always_comb begin
    ack_tgl_n = ack_tgl;
    initp_n   = initp_q;
    if (req_s != ack_tgl) begin
      initp_n   = hold_q;
      ack_tgl_n = req_s;
    end
  end

  always_ff @(posedge clk_p or negedge rst_pn) begin
    if (!rst_pn) begin
      ack_tgl <= 1'b0;
      initp_q <= 1'b1;
    end else begin
      ack_tgl <= ack_tgl_n;
      initp_q <= initp_n;
    end
  end

  assign init_p = initp_q;
endmodule

// File: rtl/cmc_regs.sv
module cmc_regs
  import cmc_pkg::*;
(
  input  logic             clk_h,
  input  logic             rst_hn,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             init_seen,
  input  logic             tx_pend_s,
  input  logic             bus_idle_s,
  output ctl_t             ctl,
  output logic             csa,
  output logic             init_want
);
  ctl_t ctl_q, ctl_n;
  logic csa_q, csa_n;
  logic want_q, want_n;
  logic guard;
  logic quiet;

  assign guard = ctl_q.cce & init_seen;
  assign quiet = ~tx_pend_s & bus_idle_s;

  always_comb begin
    ctl_n  = ctl_q;
    want_n = want_q;
    if (wr) begin
      want_n      = wdata[B_INIT];
      ctl_n.cce   = wdata[B_CCE];
      ctl_n.csr   = wdata[B_CSR];
      ctl_n.nortx = wdata[B_NORTX];
      ctl_n.tst   = wdata[B_TST];
      ctl_n.fd    = wdata[B_FD];
      ctl_n.brs   = wdata[B_BRS];
      ctl_n.pexd  = wdata[B_PEXD];
      ctl_n.eflt  = wdata[B_EFLT];
      ctl_n.pause = wdata[B_PAUSE];
      // guarded bits: set only under guard, clear anytime
      ctl_n.mon   = wdata[B_MON] & (ctl_q.mon | guard);
      ctl_n.rom   = wdata[B_ROM] & (ctl_q.rom | guard);
    end
    // clock stop request pins the init request high
    if (ctl_n.csr) want_n = 1'b1;
  end

  always_comb begin
    csa_n = csa_q;
    if (!ctl_q.csr)                  csa_n = 1'b0;
    else if (init_seen && quiet)     csa_n = 1'b1;
  end

  always_ff @(posedge clk_h or negedge rst_hn) begin
    if (!rst_hn) begin
      ctl_q  <= '0;
      csa_q  <= 1'b0;
      want_q <= 1'b1;
    end else begin
      ctl_q  <= ctl_n;
      csa_q  <= csa_n;
      want_q <= want_n;
    end
  end

  assign ctl       = ctl_q;
  assign csa       = csa_q;
  assign init_want = want_q;
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_h,
  input  logic             rst_hn,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             cfg_chg_en,
  output logic             test_wr_en,
  input  logic             clk_p,
  input  logic             rst_pn,
  input  logic             tx_pend_p,
  input  logic             bus_idle_p,
  output logic             p_init,
  output logic             p_fd_en,
  output logic             p_brs_en,
  output logic             p_mon,
  output logic             p_restrict,
  output logic             p_no_retx,
  output logic             p_tx_pause,
  output logic             p_edge_filt,
  output logic             p_pexc_dis,
  output logic             p_test
);
  ctl_t              ctl;
  logic              csa;
  logic              init_want;
  logic              init_seen;
  logic [1:0]        stat_s;
  logic [N_MODE-1:0] mode_h;
  logic [N_MODE-1:0] mode_p;

  // protocol status into host domain: {tx_pend, bus_idle}
  cmc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_stat_sync (
    .clk(clk_h), .rst_n(rst_hn), .d({tx_pend_p, bus_idle_p}), .q(stat_s)
  );

  cmc_regs u_regs (
    .clk_h     (clk_h),
    .rst_hn    (rst_hn),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .init_seen (init_seen),
    .tx_pend_s (stat_s[1]),
    .bus_idle_s(stat_s[0]),
    .ctl       (ctl),
    .csa       (csa),
    .init_want (init_want)
  );

  cmc_init_xfer #(.STAGES(SYNC_STAGES)) u_init (
    .clk_h    (clk_h),
    .rst_hn   (rst_hn),
    .init_want(init_want),
    .init_seen(init_seen),
    .clk_p    (clk_p),
    .rst_pn   (rst_pn),
    .init_p   (p_init)
  );

  // static mode bits; bit-rate switch masked by FD enable before crossing
  assign mode_h = {ctl.pause, ctl.eflt, ctl.pexd, ctl.tst, ctl.nortx,
                   ctl.rom, ctl.mon, ctl.brs & ctl.fd, ctl.fd};

  cmc_sync #(.W(N_MODE), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_mode_sync (
    .clk(clk_p), .rst_n(rst_pn), .d(mode_h), .q(mode_p)
  );

  assign {p_tx_pause, p_edge_filt, p_pexc_dis, p_test, p_no_retx,
          p_restrict, p_mon, p_brs_en, p_fd_en} = mode_p;

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[B_INIT]  = init_seen;
    reg_rdata[B_CCE]   = ctl.cce;
    reg_rdata[B_ROM]   = ctl.rom;
    reg_rdata[B_CSA]   = csa;
    reg_rdata[B_CSR]   = ctl.csr;
    reg_rdata[B_MON]   = ctl.mon;
    reg_rdata[B_NORTX] = ctl.nortx;
    reg_rdata[B_TST]   = ctl.tst;
    reg_rdata[B_FD]    = ctl.fd;
    reg_rdata[B_BRS]   = ctl.brs;
    reg_rdata[B_PEXD]  = ctl.pexd;
    reg_rdata[B_EFLT]  = ctl.eflt;
    reg_rdata[B_PAUSE] = ctl.pause;
  end

  assign cfg_chg_en = ctl.cce & init_seen;
  assign test_wr_en = ctl.tst;
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker (
  input logic        clk_h,
  input logic        rst_hn,
  input logic        clk_p,
  input logic        rst_pn,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        cfg_chg_en,
  input logic        p_brs_en,
  input logic        p_fd_en
);
  // R2: reserved bits read 0
  a_r2_reserved_zero: assert property (@(posedge clk_h) disable iff (!rst_hn)
    (reg_rdata[31:15] == '0) && (reg_rdata[11:10] == 2'b00));

  // R3: monitoring bit cannot be set without the guard
  a_r3_mon_guard: assert property (@(posedge clk_h) disable iff (!rst_hn)
    (reg_wr && reg_wdata[5] && !reg_rdata[5] && !(reg_rdata[1] && reg_rdata[0]))
      |=> !reg_rdata[5]);

  // R3: restricted bit cannot be set without the guard
  a_r3_rom_guard: assert property (@(posedge clk_h) disable iff (!rst_hn)
    (reg_wr && reg_wdata[2] && !reg_rdata[2] && !(reg_rdata[1] && reg_rdata[0]))
      |=> !reg_rdata[2]);

  // R4: protected-register enable only with both bits set
  a_r4_cfg_enable: assert property (@(posedge clk_h) disable iff (!rst_hn)
    cfg_chg_en |-> (reg_rdata[1] && reg_rdata[0]));

  // R7: acknowledge implies init is active
  a_r7_csa_init: assert property (@(posedge clk_h) disable iff (!rst_hn)
    reg_rdata[3] |-> reg_rdata[0]);

  // R7: acknowledge drops the cycle after the request is cleared
  a_r7_csa_drop: assert property (@(posedge clk_h) disable iff (!rst_hn)
    $fell(reg_rdata[4]) |=> !reg_rdata[3]);

  // R8: bit-rate switch never without FD
  a_r8_brs_masked: assert property (@(posedge clk_p) disable iff (!rst_pn)
    p_brs_en |-> p_fd_en);
endmodule

bind can_mode_ctrl cmc_checker u_chk (
  .clk_h     (clk_h),
  .rst_hn    (rst_hn),
  .clk_p     (clk_p),
  .rst_pn    (rst_pn),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cfg_chg_en(cfg_chg_en),
  .p_brs_en  (p_brs_en),
  .p_fd_en   (p_fd_en)
);

// File: tb/tb_can_mode_ctrl.sv
module tb_can_mode_ctrl;
  localparam int TH = 10;
  localparam int TP = 14;
  localparam int NV = 9;
  localparam logic [31:0] VW [NV] = '{
    32'h0000_0021, 32'h0000_0003, 32'h0000_0027, 32'h0000_0001, 32'h0000_0003,
    32'h0000_0025, 32'h0000_0021, 32'hFFFF_FFE7, 32'h0000_0001};
  localparam logic [31:0] VE [NV] = '{
    32'h0000_0001, 32'h0000_0003, 32'h0000_0027, 32'h0000_0001, 32'h0000_0003,
    32'h0000_0025, 32'h0000_0021, 32'h0000_73E3, 32'h0000_0001};

  logic clk_h = 0, clk_p = 0, rst_hn = 0, rst_pn = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic tx_pend_p = 0, bus_idle_p = 1;
  logic [31:0] reg_rdata;
  logic cfg_chg_en, test_wr_en, p_init, p_fd_en, p_brs_en, p_mon, p_restrict;
  logic p_no_retx, p_tx_pause, p_edge_filt, p_pexc_dis, p_test;
  int total = 0, bad = 0;
  bit done = 0;

  always #(TH/2) clk_h = ~clk_h;
  always #(TP/2) clk_p = ~clk_p;

  can_mode_ctrl dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk_h);
    reg_wr = 1; reg_wdata = d;
    @(posedge clk_h); #1;
    reg_wr = 0;
    @(negedge clk_h);
  endtask

  task automatic wait_h(int n);
    repeat (n) @(negedge clk_h);
  endtask

  function automatic logic [9:0] pvec();
    return {p_init, p_fd_en, p_brs_en, p_mon, p_restrict, p_no_retx,
            p_tx_pause, p_edge_filt, p_pexc_dis, p_test};
  endfunction

  initial begin
    #(TH*20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lag;
    logic saw_p;
    #(TH*3 + 2); rst_hn = 1; rst_pn = 1;
    wait_h(2);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 32'h1);
    chk("R1 proto outputs", {22'd0, pvec()}, {22'd0, 10'b10_0000_0000});
    chk("R1 enables", {30'd0, cfg_chg_en, test_wr_en}, 32'd0);

    // table: R2 field layout / reserved, R3 guarded bits
    for (int i = 0; i < NV; i++) begin
      wr(VW[i]);
      chk($sformatf("R2/R3 vector %0d", i), reg_rdata, VE[i]);
      if (i == 7) chk("R4 test_wr_en", {31'd0, test_wr_en}, 32'd1);
      if (i == 4) chk("R4 cfg_chg_en on", {31'd0, cfg_chg_en}, 32'd1);
    end

    // R9 static bits to protocol domain
    wr(32'h0000_70C1);
    wait_h(8);
    chk("R9 proto outputs", {22'd0, pvec()}, {22'd0, 10'b10_0001_1111});
    // R8 bit rate switch masked without FD
    wr(32'h0000_0201);
    wait_h(8);
    chk("R8 brs masked", {30'd0, p_brs_en, p_fd_en}, 32'd0);
    wr(32'h0000_0301);
    wait_h(8);
    chk("R8 brs with fd", {30'd0, p_brs_en, p_fd_en}, 32'd3);
    wr(32'h0000_0001);

    // R5 init handshake lag
    wr(32'h0000_0000);
    lag = 1; saw_p = 1;
    while (reg_rdata[0] && lag < 60) begin
      saw_p = p_init; @(negedge clk_h); lag++;
    end
    chk("R5 init readback", {31'd0, reg_rdata[0]}, 32'd0);
    chk("R5 lag >= 4", {31'd0, lag >= 4}, 32'd1);
    chk("R5 proto init cleared first", {31'd0, p_init}, 32'd0);

    // R3/R4 guard fails while init is 0
    wr(32'h0000_0022);
    chk("R3 mon rejected init=0", reg_rdata, 32'h2);
    chk("R4 cfg_chg_en off init=0", {31'd0, cfg_chg_en}, 32'd0);

    // R6 clock stop forces init
    tx_pend_p = 1; bus_idle_p = 0;
    wr(32'h0000_0012);
    lag = 0;
    while (!reg_rdata[0] && lag < 60) begin @(negedge clk_h); lag++; end
    chk("R6 init forced", {31'd0, reg_rdata[0]}, 32'd1);
    chk("R6 proto init", {31'd0, p_init}, 32'd1);
    wr(32'h0000_0012 & ~32'h1);
    wait_h(20);
    chk("R6 init write blocked", {31'd0, reg_rdata[0]}, 32'd1);
    chk("R7 no csa while pending", {31'd0, reg_rdata[3]}, 32'd0);
    tx_pend_p = 0;
    wait_h(10);
    chk("R7 no csa bus busy", {31'd0, reg_rdata[3]}, 32'd0);
    bus_idle_p = 1;
    wait_h(8);
    chk("R7 csa set", {31'd0, reg_rdata[3]}, 32'd1);
    chk("R4 cfg_chg_en init via csr", {31'd0, cfg_chg_en}, 32'd1);
    // R2 write to csa ignored; R7 clear request
    @(negedge clk_h);
    reg_wr = 1; reg_wdata = 32'h0000_000B;
    @(posedge clk_h); #1; reg_wr = 0;
    @(posedge clk_h); #1;
    @(negedge clk_h);
    chk("R7 csa cleared", reg_rdata, 32'h0000_0003);
    wait_h(20);
    chk("R7 init stays", {31'd0, reg_rdata[0]}, 32'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule